// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt request pins and turns them into clean, maskable interrupt outputs for a processor. Each pin is brought into the clock domain by a two-stage synchroniser. A per-pin sense code then decides whether a rising edge, a falling edge, either edge, a low level or a high level counts as a request. A request sets a pending bit. Software reads the pending bits and clears them through a small register bus.

A pending pin raises its own output only when three things hold. It must be unmasked through the paired mask-set and mask-clear ports, and its 4-bit priority field must be non-zero. Also, the individual-output mode bit must be set. A combined output ORs all qualified pins and does not depend on the mode bit. Fields are packed most-significant-first, so pin 0 always owns the top field of every register.

Top module: `xpin_irq_ctrl`

Register addresses on `bus_addr`: 0 sense, 1 priority, 2 pending source, 3 mask-set, 4 mask-clear, 5 mode. The mask-set and mask-clear ports are write-only and read back as zero.

## Requirements
- R1: After reset, every output is low. The sense, priority, pending and mode registers read as zero, and every pin is masked.
- R2: The sense register (address 0) holds one SENSE_W-bit field per pin. The field for pin n sits at bit offset 32-(n+1)*SENSE_W, and the register reads back what was written.
- R3: The priority register (address 1) holds a 4-bit field per pin at bit offset 32-(n+1)*4. A field of 0 keeps that pin's output low while its pending bit stays set.
- R4: Sense code 1 sets the pending bit once for each rising transition of the pin. Sense code 0 sets it once for each falling transition.
- R5: Sense code 4 sets the pending bit on both transitions. Codes 5 to 15 never set it.
- R6: Sense code 3 (high level) and code 2 (low level) set the pending bit on every cycle in which the level is active, so a clear written during that time has no lasting effect.
- R7: Reading address 2 returns pin n's pending bit at bit SRC_W-1-n, with all other bits zero.
- R8: Writing address 2 clears each pending bit whose data bit (at SRC_W-1-n) is 0 and leaves each bit written as 1 unchanged. A request in the same cycle wins over the clear.
- R9: A 1 at bit SRC_W-1-n written to address 3 masks pin n, and a 1 written there to address 4 unmasks it. Zero bits have no effect at either address.
- R10: Pin n's output is high only when it is pending, unmasked and has non-zero priority. `irq_any_o` is the OR of these qualified pins.
- R11: Bit 23 of the mode register (address 5) enables the per-pin outputs. While it is 0, `irq_o` stays all-zero, but `irq_any_o` still reflects the qualified pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | NUM_PINS | Asynchronous interrupt request pins |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| irq_o | output | NUM_PINS | Per-pin qualified interrupt outputs |
| irq_any_o | output | 1 | OR of all qualified pins |

## Verification
The bench builds the block with eight pins, 4-bit sense fields, an 8-bit pending/mask register and the mode register present. The 4-bit fields bring the both-edges code and the undecoded codes 5 to 15 within reach. With eight pins, both pin 0 at the top bit and pin 7 at the bottom bit are exercised. Directed tasks cover each sense code, clears that race a held level, mask writes with zero data, a zero priority field and the mode bit turned off.

// File: rtl/xpin_pkg.sv
package xpin_pkg;

   localparam logic [2:0] ADR_SENSE = 3'd0;
   localparam logic [2:0] ADR_PRIO  = 3'd1;
   localparam logic [2:0] ADR_SRC   = 3'd2;
   localparam logic [2:0] ADR_MSET  = 3'd3;
   localparam logic [2:0] ADR_MCLR  = 3'd4;
   localparam logic [2:0] ADR_MODE  = 3'd5;

   localparam int MODE_BIT = 23;
   localparam int PRIO_W   = 4;

   typedef enum logic [3:0] {
      SNS_FALL = 4'd0,
      SNS_RISE = 4'd1,
      SNS_LOW  = 4'd2,
      SNS_HIGH = 4'd3,
      SNS_BOTH = 4'd4
   } sense_e;

   // bits of a 32-bit register occupied by npins fields of width w, MSB-first
   function automatic logic [31:0] field_mask(input int npins, input int w);
      logic [31:0] m;
      m = '0;
      for (int n = 0; n < npins; n++)
         for (int k = 0; k < w; k++)
            m[32 - (n + 1) * w + k] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/xpin_pin_detect.sv
module xpin_pin_detect
   import xpin_pkg::*;
#(
   parameter int SENSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_i,
   input  logic [SENSE_W-1:0] sense_i,
   output logic               event_o
);

   localparam bit BOTH_OK = (SENSE_W >= 4);

   logic meta_q, cur_q, prev_q;
   logic [3:0] code;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= 1'b0;
         cur_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         meta_q <= pin_i;
         cur_q  <= meta_q;
         prev_q <= cur_q;
      end
   end

   assign code = 4'(sense_i);

   always_comb begin
      case (code)
         SNS_FALL: event_o = prev_q & ~cur_q;
         SNS_RISE: event_o = cur_q & ~prev_q;
         SNS_LOW:  event_o = ~cur_q;
         SNS_HIGH: event_o = cur_q;
         SNS_BOTH: event_o = BOTH_OK ? (cur_q ^ prev_q) : 1'b0;
         default:  event_o = 1'b0;
      endcase
   end

   // a rising-edge request lasts exactly one cycle while the code is steady
   AST_RISE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (code == SNS_RISE && event_o && $stable(sense_i)) |=> !event_o); // R4

endmodule

// File: rtl/xpin_cfg_regs.sv
module xpin_cfg_regs
   import xpin_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int SENSE_W  = 4,
   parameter bit HAS_MODE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we_i,
   input  logic [2:0]          addr_i,
   input  logic [31:0]         wdata_i,
   input  logic [NUM_PINS-1:0] pinbits_i,
   output logic [31:0]         sense_o,
   output logic [31:0]         prio_o,
   output logic [NUM_PINS-1:0] mask_o,
   output logic                indiv_o
);

   localparam logic [31:0] SENSE_MASK = field_mask(NUM_PINS, SENSE_W);
   localparam logic [31:0] PRIO_MASK  = field_mask(NUM_PINS, PRIO_W);

   logic [31:0]         sense_q, prio_q;
   logic [NUM_PINS-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sense_q <= '0;
         prio_q  <= '0;
         mask_q  <= '1;
      end else if (we_i) begin
         case (addr_i)
            ADR_SENSE: sense_q <= wdata_i & SENSE_MASK;
            ADR_PRIO:  prio_q  <= wdata_i & PRIO_MASK;
            ADR_MSET:  mask_q  <= mask_q | pinbits_i;
            ADR_MCLR:  mask_q  <= mask_q & ~pinbits_i;
            default: ;
         endcase
      end
   end

   generate
      if (HAS_MODE) begin : g_mode
         logic indiv_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               indiv_q <= 1'b0;
            else if (we_i && addr_i == ADR_MODE)
               indiv_q <= wdata_i[MODE_BIT];
         end
         assign indiv_o = indiv_q;
      end else begin : g_nomode
         assign indiv_o = 1'b1;
      end
   endgenerate

   assign sense_o = sense_q;
   assign prio_o  = prio_q;
   assign mask_o  = mask_q;

   // a set-port write never unmasks, a clear-port write never masks
   AST_MSET_NO_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == ADR_MSET) |=> ((mask_o & $past(mask_o)) == $past(mask_o))); // R9
   AST_MCLR_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == ADR_MCLR) |=> ((mask_o | $past(mask_o)) == $past(mask_o))); // R9

endmodule

// File: rtl/xpin_pend_bank.sv
module xpin_pend_bank #(
   parameter int NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] event_i,
   input  logic                clr_wr_i,
   input  logic [NUM_PINS-1:0] keep_i,
   output logic [NUM_PINS-1:0] pend_o
);

   logic [NUM_PINS-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= '0;
      else if (clr_wr_i)
         pend_q <= (pend_q & keep_i) | event_i;
      else
         pend_q <= pend_q | event_i;
   end

   assign pend_o = pend_q;

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
      AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
         event_i[n] |=> pend_o[n]); // R6
      AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr_i && !keep_i[n] && !event_i[n]) |=> !pend_o[n]); // R8
      AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr_i && keep_i[n] && pend_o[n]) |=> pend_o[n]); // R8
   end

endmodule

// File: rtl/xpin_irq_ctrl.sv
module xpin_irq_ctrl
   import xpin_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int SENSE_W  = 4,
   parameter int SRC_W    = 8,
   parameter bit HAS_MODE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic [2:0]          bus_addr,
   input  logic                bus_we,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_PINS-1:0] irq_o,
   output logic                irq_any_o
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > 8) begin : g_bad_pins
         $error("xpin_irq_ctrl: NUM_PINS must be 1..8");
      end
      if (SENSE_W != 2 && SENSE_W != 4) begin : g_bad_sense
         $error("xpin_irq_ctrl: SENSE_W must be 2 or 4");
      end
      if (SRC_W != 8 && SRC_W != 32) begin : g_bad_src
         $error("xpin_irq_ctrl: SRC_W must be 8 or 32");
      end
   endgenerate

   logic [NUM_PINS-1:0] wr_pins, events, pend, mask, qual;
   logic [31:0]         sense_q, prio_q, src_view;
   logic                indiv;

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_wbit
      assign wr_pins[n] = bus_wdata[SRC_W - 1 - n];
   end

   xpin_cfg_regs #(
      .NUM_PINS (NUM_PINS),
      .SENSE_W  (SENSE_W),
      .HAS_MODE (HAS_MODE)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (bus_we),
      .addr_i    (bus_addr),
      .wdata_i   (bus_wdata),
      .pinbits_i (wr_pins),
      .sense_o   (sense_q),
      .prio_o    (prio_q),
      .mask_o    (mask),
      .indiv_o   (indiv)
   );

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      localparam int SSH = 32 - (n + 1) * SENSE_W;
      localparam int PSH = 32 - (n + 1) * PRIO_W;

      xpin_pin_detect #(.SENSE_W(SENSE_W)) i_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_i   (pins_i[n]),
         .sense_i (sense_q[SSH +: SENSE_W]),
         .event_o (events[n])
      );

      assign qual[n] = pend[n] & ~mask[n] & (|prio_q[PSH +: PRIO_W]);

      AST_PRIO_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         (prio_q[PSH +: PRIO_W] == '0) |-> !irq_o[n]); // R3
      AST_MASKSET_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADR_MSET && bus_wdata[SRC_W - 1 - n]) |=> !irq_o[n]); // R9
   end

   xpin_pend_bank #(.NUM_PINS(NUM_PINS)) i_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_i  (events),
      .clr_wr_i (bus_we && bus_addr == ADR_SRC),
      .keep_i   (wr_pins),
      .pend_o   (pend)
   );

   assign irq_o     = indiv ? qual : '0;
   assign irq_any_o = |qual;

   always_comb begin
      src_view = '0;
      for (int n = 0; n < NUM_PINS; n++)
         src_view[SRC_W - 1 - n] = pend[n];
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_SENSE: bus_rdata = sense_q;
         ADR_PRIO:  bus_rdata = prio_q;
         ADR_SRC:   bus_rdata = src_view;
         ADR_MODE:  bus_rdata[MODE_BIT] = HAS_MODE ? indiv : 1'b0;
         default:   bus_rdata = '0;
      endcase
   end

   AST_ANY_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any_o |-> ($countones(pend) > 0)); // R10
   AST_IRQ_SUBSET_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o != '0) |-> irq_any_o); // R10
   AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADR_MODE && !bus_wdata[MODE_BIT]) |=> (irq_o == '0)); // R11

endmodule

// File: tb/test_xpin_irq_ctrl.sv
module test_xpin_irq_ctrl;

   localparam logic [2:0] A_SENSE = 3'd0, A_PRIO = 3'd1, A_SRC = 3'd2,
                          A_MSET = 3'd3, A_MCLR = 3'd4, A_MODE = 3'd5;
   localparam logic [31:0] MODE_ON = 32'h0080_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pins = '0;
   logic [2:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  irq;
   logic        any;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   xpin_irq_ctrl #(.NUM_PINS(8), .SENSE_W(4), .SRC_W(8), .HAS_MODE(1'b1)) i_xpin_irq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_i    (pins),
      .bus_addr  (addr),
      .bus_we    (we),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_o     (irq),
      .irq_any_o (any)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0; wdata = '0;
      #1;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic set_pin(input int p, input logic v);
      @(negedge clk);
      pins[p] = v;
      wait_cyc(4);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(A_SENSE, d); chk("R1", "sense after reset", d, 32'h0);
      rd(A_PRIO, d);  chk("R1", "prio after reset", d, 32'h0);
      rd(A_SRC, d);   chk("R1", "source after reset", d, 32'h0);
      rd(A_MODE, d);  chk("R1", "mode after reset", d, 32'h0);
      chk("R1", "irq after reset", {24'h0, irq}, 32'h0);
      chk("R1", "any after reset", {31'h0, any}, 32'h0);
   endtask

   task automatic t_layout;
      logic [31:0] d;
      wr(A_SENSE, 32'h0123_4567); rd(A_SENSE, d);
      chk("R2", "sense readback", d, 32'h0123_4567);
      wr(A_PRIO, 32'hF0A5_3C01); rd(A_PRIO, d);
      chk("R3", "prio readback", d, 32'hF0A5_3C01);
   endtask

   task automatic t_rise_fall;
      logic [31:0] d;
      wr(A_SENSE, 32'h1111_1111);
      wr(A_PRIO, 32'hFFFF_FFFF);
      wr(A_MODE, MODE_ON);
      wr(A_MCLR, 32'h0000_00FF);
      wr(A_SRC, 32'h0);
      set_pin(2, 1'b1);
      rd(A_SRC, d); chk("R7", "pin2 rise at bit5", d, 32'h20);
      chk("R10", "irq pin2", {24'h0, irq}, 32'h04);
      chk("R10", "any pin2", {31'h0, any}, 32'h1);
      wr(A_SRC, 32'hDF);
      set_pin(2, 1'b0);
      rd(A_SRC, d); chk("R4", "fall ignored under rise code", d, 32'h0);
      wr(A_SENSE, 32'h1101_1111);
      set_pin(2, 1'b1);
      rd(A_SRC, d); chk("R4", "rise ignored under fall code", d, 32'h0);
      set_pin(2, 1'b0);
      rd(A_SRC, d); chk("R4", "fall pends under fall code", d, 32'h20);
      wr(A_SRC, 32'h0);
   endtask

   task automatic t_both;
      logic [31:0] d;
      wr(A_SENSE, 32'h1111_1114);
      set_pin(7, 1'b1);
      rd(A_SRC, d); chk("R5", "both: rise on pin7 at bit0", d, 32'h01);
      wr(A_SRC, 32'h0);
      set_pin(7, 1'b0);
      rd(A_SRC, d); chk("R5", "both: fall on pin7", d, 32'h01);
      wr(A_SRC, 32'h0);
      wr(A_SENSE, 32'h1111_1115);
      set_pin(7, 1'b1);
      set_pin(7, 1'b0);
      rd(A_SRC, d); chk("R5", "code 5 never pends", d, 32'h0);
   endtask

   task automatic t_level;
      logic [31:0] d;
      wr(A_SENSE, 32'h1113_1111);
      set_pin(3, 1'b1);
      rd(A_SRC, d); chk("R6", "high level pends", d, 32'h10);
      wr(A_SRC, 32'h0);
      rd(A_SRC, d); chk("R6", "clear lost while high held", d, 32'h10);
      set_pin(3, 1'b0);
      wr(A_SRC, 32'h0);
      rd(A_SRC, d); chk("R6", "clear after level drops", d, 32'h0);
      wr(A_SENSE, 32'h1111_2111);
      wait_cyc(4);
      rd(A_SRC, d); chk("R6", "low level pends pin4", d, 32'h08);
      set_pin(4, 1'b1);
      wr(A_SRC, 32'h0);
      rd(A_SRC, d); chk("R6", "low level released", d, 32'h0);
      wr(A_SENSE, 32'h1111_1111);
      set_pin(4, 1'b0);
   endtask

   task automatic t_keep;
      logic [31:0] d;
      set_pin(0, 1'b1);
      set_pin(1, 1'b1);
      rd(A_SRC, d); chk("R7", "pins0,1 at bits7,6", d, 32'hC0);
      wr(A_SRC, 32'h7F);
      rd(A_SRC, d); chk("R8", "zero clears pin0, one keeps pin1", d, 32'h40);
      chk("R10", "irq pin1 only", {24'h0, irq}, 32'h02);
   endtask

   task automatic t_mask;
      wr(A_MSET, 32'h40);
      chk("R9", "mask-set pin1 quiets irq", {24'h0, irq}, 32'h0);
      chk("R10", "masked pin drops any", {31'h0, any}, 32'h0);
      wr(A_MCLR, 32'h0);
      chk("R9", "mask-clear zeros no effect", {24'h0, irq}, 32'h0);
      wr(A_MCLR, 32'h40);
      chk("R9", "mask-clear pin1 restores", {24'h0, irq}, 32'h02);
      wr(A_MSET, 32'h0);
      chk("R9", "mask-set zeros no effect", {24'h0, irq}, 32'h02);
   endtask

   task automatic t_prio;
      logic [31:0] d;
      wr(A_PRIO, 32'hF0FF_FFFF);
      chk("R3", "zero prio blocks pin1", {24'h0, irq}, 32'h0);
      chk("R3", "zero prio blocks any", {31'h0, any}, 32'h0);
      rd(A_SRC, d); chk("R3", "pending kept under zero prio", d, 32'h40);
      wr(A_PRIO, 32'h01FF_FFFF);
      chk("R3", "nonzero prio re-enables", {24'h0, irq}, 32'h02);
   endtask

   task automatic t_mode;
      logic [31:0] d;
      wr(A_MODE, 32'h0);
      chk("R11", "mode off silences irq", {24'h0, irq}, 32'h0);
      chk("R11", "mode off keeps any", {31'h0, any}, 32'h1);
      rd(A_MODE, d); chk("R11", "mode readback off", d, 32'h0);
      wr(A_MODE, MODE_ON);
      chk("R11", "mode on restores irq", {24'h0, irq}, 32'h02);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(1);
      t_reset;
      t_layout;
      t_rise_fall;
      t_both;
      t_level;
      t_keep;
      t_mask;
      t_prio;
      t_mode;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1..R11 watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule